// File: doc/BRIEF.md
# Branch Target and Condition Unit

This block resolves the next program counter for a 64-bit RISC core. For the instruction word at the current fetch address, it produces three candidate addresses in parallel: the sequential address (fetch address plus one 4-byte instruction), the PC-relative branch target, and the register-indirect jump target. It also evaluates the branch condition against the value of register A and raises a taken flag.

For the unconditional branch-and-link and register-jump forms, it supplies a link value (the sequential address), the index of the register to write and a write enable. The write enable is held low when that register is the hard-wired zero register.

All decode, condition and target logic is combinational. The selected next PC is captured in a register on every clock edge. Fetch, prediction and flush control sit outside the block.

Top module: `brt_unit`

## Requirements
- R1: `seqPc` equals `fetchPc + 4`, modulo 2^64.
- R2: `branchTarget` equals `seqPc` plus the displacement in `instrWord[20:0]`. That field is treated as a signed word count (bit 20 is the sign), so it is multiplied by 4 and sign-extended to 64 bits.
- R3: `jumpTarget` equals `regBVal` with bit 0 forced to zero.
- R4: Opcodes (`instrWord[31:26]`) 0x30 and 0x34 always raise `taken`.
- R5: The conditional opcodes test `regAVal` and raise `taken` when the test holds. Bit 0 clear tests 0x38 and bit 0 set tests 0x3C. The remaining opcodes compare `regAVal` as a signed 64-bit value against zero: 0x39 equal, 0x3D not equal, 0x3A less than, 0x3B less or equal, 0x3E greater or equal, 0x3F greater than.
- R6: Opcode 0x1A always raises `taken`, and its destination is `jumpTarget`.
- R7: `linkWe` is high only for opcodes 0x30, 0x34 and 0x1A, and only when the A field (`instrWord[25:21]`) is not 31. `linkIdx` is the A field and `linkValue` is `seqPc`. Conditional branches never link.
- R8: Any opcode other than those in R4 to R6 leaves `taken` and `linkWe` low.
- R9: `nextPc` resets to 0. On each rising clock edge it loads one of three values: `jumpTarget` for a taken 0x1A, `branchTarget` for any other taken branch, and `seqPc` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrWord | input | 32 | Current instruction word |
| fetchPc | input | 64 | Address the instruction was fetched from |
| regAVal | input | 64 | Value of register A |
| regBVal | input | 64 | Value of register B |
| seqPc | output | 64 | Sequential next address |
| branchTarget | output | 64 | PC-relative target |
| jumpTarget | output | 64 | Register-indirect target, bit 0 cleared |
| taken | output | 1 | Control transfer taken |
| linkWe | output | 1 | Link register write enable |
| linkIdx | output | 5 | Link register index |
| linkValue | output | 64 | Return address to write |
| nextPc | output | 64 | Registered next PC |

## Verification
The hardest cases to reach are the sign boundaries of the condition tests. Each signed compare must flip at exactly -1, 0 and +1. The most negative and most positive 64-bit values must not be mistaken for small numbers. The low-bit tests must ignore the sign. The stimulus table therefore drives every conditional opcode with register A at -1, 0 and +1, and adds the two 64-bit extremes. Directed cases then push the displacement to its largest forward and backward values, wrap the fetch address past 2^64, and set the A field to 31 on the linking forms to show that the branch is still taken while the write is suppressed.

// File: rtl/brt_pkg.sv
package brt_pkg;

  // Instruction field positions (fixed by the encoding the decoder relies on)
  localparam int OPC_HI = 31;
  localparam int OPC_LO = 26;
  localparam int RA_HI  = 25;
  localparam int RA_LO  = 21;
  localparam int OPC_W  = OPC_HI - OPC_LO + 1;
  localparam int RIDX_W = RA_HI - RA_LO + 1;

  localparam logic [RIDX_W-1:0] HARD_ZERO_REG = 5'd31;

  // Control-transfer opcodes
  localparam logic [OPC_W-1:0] OPC_REG_JUMP   = 6'h1A;
  localparam logic [OPC_W-1:0] OPC_GO         = 6'h30;
  localparam logic [OPC_W-1:0] OPC_GO_LINK    = 6'h34;
  localparam logic [OPC_W-1:0] OPC_IF_EVEN    = 6'h38;
  localparam logic [OPC_W-1:0] OPC_IF_ZERO    = 6'h39;
  localparam logic [OPC_W-1:0] OPC_IF_NEG     = 6'h3A;
  localparam logic [OPC_W-1:0] OPC_IF_NONPOS  = 6'h3B;
  localparam logic [OPC_W-1:0] OPC_IF_ODD     = 6'h3C;
  localparam logic [OPC_W-1:0] OPC_IF_NONZERO = 6'h3D;
  localparam logic [OPC_W-1:0] OPC_IF_NONNEG  = 6'h3E;
  localparam logic [OPC_W-1:0] OPC_IF_POS     = 6'h3F;

  typedef enum logic [3:0] {
    CS_NONE,
    CS_ALWAYS,
    CS_JUMP,
    CS_EVEN,
    CS_ZERO,
    CS_NEG,
    CS_NONPOS,
    CS_ODD,
    CS_NONZERO,
    CS_NONNEG,
    CS_POS
  } condSel_e;

  // Summary of register A produced by the datapath
  typedef struct packed {
    logic isZero;
    logic isNeg;
    logic lowBit;
  } regFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeBranch;
    logic takeJump;
    logic linkWe;
  } pcStrobes_t;

endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [RIDX_W-1:0] aIdx,
  input  regFlags_t         flags,
  output pcStrobes_t        strobes
);

  condSel_e sel;
  logic     condMet;
  logic     linkForm;

  // Opcode to condition selector
  always_comb begin
    unique case (opcode)
      OPC_GO, OPC_GO_LINK: sel = CS_ALWAYS;
      OPC_REG_JUMP:        sel = CS_JUMP;
      OPC_IF_EVEN:         sel = CS_EVEN;
      OPC_IF_ZERO:         sel = CS_ZERO;
      OPC_IF_NEG:          sel = CS_NEG;
      OPC_IF_NONPOS:       sel = CS_NONPOS;
      OPC_IF_ODD:          sel = CS_ODD;
      OPC_IF_NONZERO:      sel = CS_NONZERO;
      OPC_IF_NONNEG:       sel = CS_NONNEG;
      OPC_IF_POS:          sel = CS_POS;
      default:             sel = CS_NONE;
    endcase
  end

  // Condition evaluation from the register summary flags
  always_comb begin
    unique case (sel)
      CS_ALWAYS:  condMet = 1'b1;
      CS_EVEN:    condMet = ~flags.lowBit;
      CS_ODD:     condMet = flags.lowBit;
      CS_ZERO:    condMet = flags.isZero;
      CS_NONZERO: condMet = ~flags.isZero;
      CS_NEG:     condMet = flags.isNeg;
      CS_NONPOS:  condMet = flags.isNeg | flags.isZero;
      CS_NONNEG:  condMet = ~flags.isNeg;
      CS_POS:     condMet = ~flags.isNeg & ~flags.isZero;
      default:    condMet = 1'b0;
    endcase
  end

  assign linkForm = (sel == CS_JUMP) || (opcode == OPC_GO) || (opcode == OPC_GO_LINK);

  always_comb begin
    strobes            = '0;
    strobes.takeJump   = (sel == CS_JUMP);
    strobes.takeBranch = condMet;
    strobes.linkWe     = linkForm && (aIdx != HARD_ZERO_REG);
  end

endmodule

// File: rtl/brt_dpath.sv
module brt_dpath
  import brt_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          DISP_W     = 21,
  parameter int          INSN_BYTES = 4,
  parameter logic [63:0] RESET_PC   = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DISP_W-1:0] dispField,
  input  logic [XLEN-1:0]   fetchPc,
  input  logic [XLEN-1:0]   regAVal,
  input  logic [XLEN-1:0]   regBVal,
  input  pcStrobes_t        strobes,
  output regFlags_t         flags,
  output logic [XLEN-1:0]   seqPc,
  output logic [XLEN-1:0]   branchTarget,
  output logic [XLEN-1:0]   jumpTarget,
  output logic [XLEN-1:0]   nextPc
);

  localparam int SHIFT  = $clog2(INSN_BYTES);
  localparam int EXT_W  = XLEN - DISP_W - SHIFT;

  logic [XLEN-1:0] byteOffset;
  logic [XLEN-1:0] selectedPc;

  // Register A summary for the condition logic
  assign flags.isZero = (regAVal == '0);
  assign flags.isNeg  = regAVal[XLEN-1];
  assign flags.lowBit = regAVal[0];

  // Three candidate addresses in parallel
  assign seqPc        = fetchPc + XLEN'(INSN_BYTES);
  assign byteOffset   = {{EXT_W{dispField[DISP_W-1]}}, dispField, {SHIFT{1'b0}}};
  assign branchTarget = seqPc + byteOffset;
  assign jumpTarget   = {regBVal[XLEN-1:1], 1'b0};

  always_comb begin
    if (strobes.takeJump)        selectedPc = jumpTarget;
    else if (strobes.takeBranch) selectedPc = branchTarget;
    else                         selectedPc = seqPc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nextPc <= RESET_PC[XLEN-1:0];
    else        nextPc <= selectedPc;
  end

endmodule

// File: rtl/brt_unit.sv
module brt_unit
  import brt_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          DISP_W     = 21,
  parameter int          INSN_BYTES = 4,
  parameter logic [63:0] RESET_PC   = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instrWord,
  input  logic [XLEN-1:0]   fetchPc,
  input  logic [XLEN-1:0]   regAVal,
  input  logic [XLEN-1:0]   regBVal,
  output logic [XLEN-1:0]   seqPc,
  output logic [XLEN-1:0]   branchTarget,
  output logic [XLEN-1:0]   jumpTarget,
  output logic              taken,
  output logic              linkWe,
  output logic [RIDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]   linkValue,
  output logic [XLEN-1:0]   nextPc
);

  pcStrobes_t strobes;
  regFlags_t  flags;

  brt_ctrl i_ctrl (
    .opcode  (instrWord[OPC_HI:OPC_LO]),
    .aIdx    (instrWord[RA_HI:RA_LO]),
    .flags   (flags),
    .strobes (strobes)
  );

  brt_dpath #(
    .XLEN       (XLEN),
    .DISP_W     (DISP_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_PC   (RESET_PC)
  ) i_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .dispField    (instrWord[DISP_W-1:0]),
    .fetchPc      (fetchPc),
    .regAVal      (regAVal),
    .regBVal      (regBVal),
    .strobes      (strobes),
    .flags        (flags),
    .seqPc        (seqPc),
    .branchTarget (branchTarget),
    .jumpTarget   (jumpTarget),
    .nextPc       (nextPc)
  );

  assign taken     = strobes.takeBranch | strobes.takeJump;
  assign linkWe    = strobes.linkWe;
  assign linkIdx   = instrWord[RA_HI:RA_LO];
  assign linkValue = seqPc;

endmodule

// File: rtl/brt_checker.sv
module brt_checker
  import brt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       instrWord,
  input logic [XLEN-1:0]   fetchPc,
  input logic [XLEN-1:0]   seqPc,
  input logic [XLEN-1:0]   branchTarget,
  input logic [XLEN-1:0]   jumpTarget,
  input logic              taken,
  input logic              linkWe,
  input logic [RIDX_W-1:0] linkIdx,
  input logic [XLEN-1:0]   nextPc
);

  logic [OPC_W-1:0] opc;
  logic             knownOp;

  assign opc     = instrWord[OPC_HI:OPC_LO];
  assign knownOp = (opc == OPC_REG_JUMP) || (opc == OPC_GO) || (opc == OPC_GO_LINK) ||
                   (opc[5:3] == 3'b111);

  // R1
  a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seqPc - fetchPc) == XLEN'(4));

  // R4
  a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ((opc == OPC_GO) || (opc == OPC_GO_LINK)) |-> taken);

  // R6
  a_r6_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_REG_JUMP) |-> (taken && !jumpTarget[0]));

  // R7
  a_r7_link_when_taken: assert property (@(posedge clk) disable iff (!rst_n)
    linkWe |-> (taken && (linkIdx != HARD_ZERO_REG) && (opc[5:3] != 3'b111)));

  // R8
  a_r8_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !knownOp |-> (!taken && !linkWe));

  // R9
  a_r9_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> nextPc == $past(taken ? ((opc == OPC_REG_JUMP) ? jumpTarget : branchTarget)
                                   : seqPc));

endmodule

bind brt_unit brt_checker #(.XLEN(XLEN)) i_brt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .instrWord    (instrWord),
  .fetchPc      (fetchPc),
  .seqPc        (seqPc),
  .branchTarget (branchTarget),
  .jumpTarget   (jumpTarget),
  .taken        (taken),
  .linkWe       (linkWe),
  .linkIdx      (linkIdx),
  .nextPc       (nextPc)
);

// File: tb/test_brt_unit.sv
module test_brt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 33;

  typedef struct packed {
    logic [5:0]  op;
    logic [63:0] aVal;
    logic        tk;
  } vec_t;

  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] Z0 = 64'h0;
  localparam logic [63:0] P1 = 64'h1;

  localparam vec_t VECS [NVEC] = '{
    '{6'h38, M1, 1'b0}, '{6'h38, Z0, 1'b1}, '{6'h38, P1, 1'b0},
    '{6'h39, M1, 1'b0}, '{6'h39, Z0, 1'b1}, '{6'h39, P1, 1'b0},
    '{6'h3A, M1, 1'b1}, '{6'h3A, Z0, 1'b0}, '{6'h3A, P1, 1'b0},
    '{6'h3B, M1, 1'b1}, '{6'h3B, Z0, 1'b1}, '{6'h3B, P1, 1'b0},
    '{6'h3C, M1, 1'b1}, '{6'h3C, Z0, 1'b0}, '{6'h3C, P1, 1'b1},
    '{6'h3D, M1, 1'b1}, '{6'h3D, Z0, 1'b0}, '{6'h3D, P1, 1'b1},
    '{6'h3E, M1, 1'b0}, '{6'h3E, Z0, 1'b1}, '{6'h3E, P1, 1'b1},
    '{6'h3F, M1, 1'b0}, '{6'h3F, Z0, 1'b0}, '{6'h3F, P1, 1'b1},
    '{6'h3A, 64'h8000_0000_0000_0000, 1'b1},
    '{6'h3F, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1},
    '{6'h3C, 64'h8000_0000_0000_0002, 1'b0},
    '{6'h30, Z0, 1'b1}, '{6'h34, M1, 1'b1}, '{6'h1A, P1, 1'b1},
    '{6'h10, Z0, 1'b0}, '{6'h29, M1, 1'b0}, '{6'h00, Z0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] fetchPc = '0;
  logic [63:0] regAVal = '0;
  logic [63:0] regBVal = '0;
  logic [63:0] seqPc, branchTarget, jumpTarget, linkValue, nextPc;
  logic        taken, linkWe;
  logic [4:0]  linkIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brt_unit i_brt_unit (
    .clk(clk), .rst_n(rst_n), .instrWord(instrWord), .fetchPc(fetchPc),
    .regAVal(regAVal), .regBVal(regBVal), .seqPc(seqPc),
    .branchTarget(branchTarget), .jumpTarget(jumpTarget), .taken(taken),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkValue(linkValue), .nextPc(nextPc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic string tagFor(input logic [5:0] op);
    if (op == 6'h30 || op == 6'h34) return "R4 always-taken";
    if (op == 6'h1A)                return "R6 register jump";
    if (op[5:3] == 3'b111)          return "R5 condition";
    return "R8 unknown opcode";
  endfunction

  // Drive one instruction, check the combinational outputs and the registered next PC
  task automatic runCase(input logic [5:0] op, input logic [4:0] aF, input logic [20:0] d,
                         input logic [63:0] pc, input logic [63:0] a, input logic [63:0] b,
                         input logic expTk);
    logic [63:0] eSeq, eBr, eJmp, eNext;
    logic        eLink;
    eSeq  = pc + 64'd4;
    eBr   = eSeq + {{41{d[20]}}, d, 2'b00};
    eJmp  = b & ~64'h1;
    eNext = !expTk ? eSeq : (op == 6'h1A ? eJmp : eBr);
    eLink = (op == 6'h30 || op == 6'h34 || op == 6'h1A) && (aF != 5'd31);
    @(negedge clk);
    instrWord = {op, aF, d};
    fetchPc   = pc;
    regAVal   = a;
    regBVal   = b;
    #1;
    chk(tagFor(op), 64'(taken), 64'(expTk));
    chk("R1 sequential", seqPc, eSeq);
    chk("R2 branch target", branchTarget, eBr);
    chk("R3 jump target", jumpTarget, eJmp);
    chk("R7 link enable", 64'(linkWe), 64'(eLink));
    if (eLink) begin
      chk("R7 link value", linkValue, eSeq);
      chk("R7 link index", 64'(linkIdx), 64'(aF));
    end
    @(posedge clk);
    #1;
    chk("R9 next pc", nextPc, eNext);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    summary();
  end

  initial begin
    // R9: reset value
    #(CLK_PERIOD * 2 + 1);
    chk("R9 reset value", nextPc, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      runCase(VECS[i].op, 5'(i % 31), 21'(i * 24593),
              64'h40_0000_0000 + 64'(i) * 64'h100, VECS[i].aVal,
              64'hC0DE_0000_0000_0000 + 64'(i * 3), VECS[i].tk);
    end

    // R2: largest forward and backward displacements
    runCase(6'h30, 5'd3, 21'h0FFFFF, 64'h1_0000_0000, Z0, Z0, 1'b1);
    runCase(6'h39, 5'd4, 21'h100000, 64'h1_0000_0000, Z0, Z0, 1'b1);
    // R1: sequential address wraps past the top of the space
    runCase(6'h3F, 5'd5, 21'h000010, 64'hFFFF_FFFF_FFFF_FFFC, Z0, Z0, 1'b0);
    // R7: A field 31 suppresses the link but not the transfer
    runCase(6'h34, 5'd31, 21'h000020, 64'h2000, Z0, Z0, 1'b1);
    runCase(6'h1A, 5'd31, 21'h000000, 64'h2000, Z0, 64'h1234_5677, 1'b1);
    // R7: taken conditional branch never links
    runCase(6'h3E, 5'd7, 21'h1FFFFF, 64'h3000, P1, Z0, 1'b1);
    // R3: odd register B target lands on an even address
    runCase(6'h1A, 5'd26, 21'h0ABCDE, 64'h4000, M1, M1, 1'b1);

    summary();
  end

endmodule